// File: doc/BRIEF.md
# Break-Before-Make Gate Sequencer

This block turns a single PWM command into two gate enables for the high-side and low-side switches of a synchronous buck power stage. It does not insert a fixed dead time. Before it turns one switch on, it waits until a comparator reports that the opposite gate has actually discharged. That comparator trips when the gate voltage falls below 0.8 V, and its digitized result reaches this block as an "off" indicator for each gate. The low-side switch stays on for the whole low part of the PWM period, and nothing cuts it off early. Because of that, the stage can carry current in either direction, sourcing or sinking.

Two protections sit alongside the sequencing:
- **On-time limit.** A clamp caps the high-side on-time in each period, which keeps the duty cycle below a ceiling.
- **Discharge timeout.** If an opposite gate does not report off within a set number of cycles, the block drops both enables and latches a fault until reset.

An inhibit input forces both gates off at the next clock edge.

Top module: `gate_bbm_ctrl`

## Requirements
- R1: `hi_en_o` and `lo_en_o` are never high in the same cycle.
- R2: `hi_en_o` rises only at a clock edge where `lo_off_i` was sampled high. While `lo_off_i` stays low after a rising PWM edge, `hi_en_o` stays low.
- R3: `lo_en_o` rises only at a clock edge where `hi_off_i` was sampled high. While `hi_off_i` stays low after a falling PWM edge, `lo_en_o` stays low.
- R4: Once on, `lo_en_o` stays high until the effective PWM command rises, whatever the off indicators do. There is no cutoff for reverse current.
- R5: A PWM high pulse is honoured for at most MAX_ON = PERIOD_CYC*MAX_DUTY_PCT/100 consecutive cycles. After that the command is treated as low until `pwm_i` falls, so the longest `hi_en_o` run is MAX_ON-1 cycles.
- R6: When `inhibit_i` is sampled high, both enables are low after that clock edge. They stay low for as long as inhibit stays high.
- R7: Consider the cycles the sequencer spends waiting for an off indicator that stays low. After TIMEOUT_CYC such cycles, `fault_o` is set and both enables go low. The fault is sticky until `rst_ni` is asserted.
- R8: After reset, all outputs are low. With `pwm_i` low and `hi_off_i` high, `lo_en_o` goes high at the second clock edge.
- R9: A PWM transition takes the conducting gate's enable low at the first clock edge that samples the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM command: 1 asks for the high-side switch, 0 for the low-side switch |
| inhibit_i | input | 1 | Forces both gates off |
| hi_off_i | input | 1 | High-side gate sensed below threshold |
| lo_off_i | input | 1 | Low-side gate sensed below threshold |
| hi_en_o | output | 1 | High-side gate enable |
| lo_en_o | output | 1 | Low-side gate enable |
| fault_o | output | 1 | Sticky discharge-timeout fault |

## Verification
The assertions assume that each off indicator is a synchronous, glitch-free level. They also assume it tracks its own enable: it falls some time after the enable rises, and it rises a bounded number of cycles after the enable falls. The random phase drives both indicators from a small gate plant in the bench. That plant raises an indicator 0 to 3 cycles after its enable falls, which is always inside the timeout, and lowers it one cycle after the enable rises. Directed phases then hold the indicators at fixed values to reach the timeout, clamp and inhibit corners on exact cycles.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_LO = 3'd1,
    ST_HI      = 3'd2,
    ST_WAIT_HI = 3'd3,
    ST_LO      = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pwm_on_clamp.sv
module pwm_on_clamp #(
  parameter int unsigned MAX_ON = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic pwm_o
);
  localparam int unsigned W = $clog2(MAX_ON + 1);
  localparam logic [W-1:0] LIMIT = W'(MAX_ON);

  logic [W-1:0] run_q;
  logic         at_lim;

  assign at_lim = (run_q == LIMIT);
  assign pwm_o  = pwm_i && !at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (!pwm_i)  run_q <= '0;
    else if (!at_lim) run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int unsigned TIMEOUT_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expired_o
);
  localparam int unsigned W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [W-1:0] LIMIT = W'(TIMEOUT_CYC - 1);

  logic [W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (cnt_q != LIMIT)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bbm_fsm.sv
module bbm_fsm
  import gate_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic inhibit_i,
  input  logic hi_off_i,
  input  logic lo_off_i,
  input  logic expired_i,
  output logic waiting_o,
  output logic change_o,
  output logic hi_en_o,
  output logic lo_en_o,
  output logic fault_o
);
  seq_state_e state_q, state_d;
  logic       fault_q, fault_d;

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    if (inhibit_i || fault_q) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:    state_d = pwm_i ? ST_WAIT_LO : ST_WAIT_HI;
        ST_WAIT_LO: begin
          if (!pwm_i)         state_d = ST_WAIT_HI;
          else if (lo_off_i)  state_d = ST_HI;
          else if (expired_i) begin
            state_d = ST_IDLE;
            fault_d = 1'b1;
          end
        end
        ST_HI:      if (!pwm_i) state_d = ST_WAIT_HI;
        ST_WAIT_HI: begin
          if (pwm_i)          state_d = ST_WAIT_LO;
          else if (hi_off_i)  state_d = ST_LO;
          else if (expired_i) begin
            state_d = ST_IDLE;
            fault_d = 1'b1;
          end
        end
        ST_LO:      if (pwm_i) state_d = ST_WAIT_LO;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  assign waiting_o = (state_q == ST_WAIT_LO) || (state_q == ST_WAIT_HI);
  assign change_o  = (state_d != state_q);
  assign hi_en_o   = (state_q == ST_HI);
  assign lo_en_o   = (state_q == ST_LO);
  assign fault_o   = fault_q;
endmodule

// File: rtl/gate_bbm_ctrl.sv
module gate_bbm_ctrl #(
  parameter int unsigned PERIOD_CYC   = 100,
  parameter int unsigned MAX_DUTY_PCT = 96,
  parameter int unsigned TIMEOUT_CYC  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic inhibit_i,
  input  logic hi_off_i,
  input  logic lo_off_i,
  output logic hi_en_o,
  output logic lo_en_o,
  output logic fault_o
);
  localparam int unsigned MAX_ON = PERIOD_CYC * MAX_DUTY_PCT / 100;

  logic pwm_eff, waiting, change, expired;

  generate
    if (MAX_DUTY_PCT >= 100) begin : g_no_clamp
      assign pwm_eff = pwm_i;
    end else begin : g_clamp
      pwm_on_clamp #(.MAX_ON(MAX_ON)) u_clamp (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pwm_i (pwm_i),
        .pwm_o (pwm_eff)
      );
    end
  endgenerate

  wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (waiting),
    .restart_i(change),
    .expired_o(expired)
  );

  bbm_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwm_i    (pwm_eff),
    .inhibit_i(inhibit_i),
    .hi_off_i (hi_off_i),
    .lo_off_i (lo_off_i),
    .expired_i(expired),
    .waiting_o(waiting),
    .change_o (change),
    .hi_en_o  (hi_en_o),
    .lo_en_o  (lo_en_o),
    .fault_o  (fault_o)
  );
endmodule

// File: rtl/gate_bbm_ctrl_chk.sv
module gate_bbm_ctrl_chk #(
  parameter int unsigned PERIOD_CYC   = 100,
  parameter int unsigned MAX_DUTY_PCT = 96
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwm_i,
  input logic inhibit_i,
  input logic hi_off_i,
  input logic lo_off_i,
  input logic hi_en_o,
  input logic lo_en_o,
  input logic fault_o
);
  localparam int unsigned MAX_ON = PERIOD_CYC * MAX_DUTY_PCT / 100;
  localparam int unsigned W = $clog2(MAX_ON + 2);

  a_r1_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_en_o && lo_en_o));

  a_r2_hi_after_lo_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_en_o) |-> $past(lo_off_i));

  a_r3_lo_after_hi_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_en_o) |-> $past(hi_off_i));

  a_r6_inhibit_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> (!hi_en_o && !lo_en_o));

  a_r7_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  a_r7_fault_gates_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!hi_en_o && !lo_en_o));

  a_r9_pwm_drop_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |=> !hi_en_o);

  generate
    if (MAX_DUTY_PCT < 100) begin : g_duty
      logic [W-1:0] hi_run_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       hi_run_q <= '0;
        else if (!hi_en_o) hi_run_q <= '0;
        else if (hi_run_q != W'(MAX_ON + 1)) hi_run_q <= hi_run_q + 1'b1;
      end
      a_r5_max_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hi_run_q < W'(MAX_ON));
    end
  endgenerate
endmodule

bind gate_bbm_ctrl gate_bbm_ctrl_chk #(
  .PERIOD_CYC  (PERIOD_CYC),
  .MAX_DUTY_PCT(MAX_DUTY_PCT)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pwm_i    (pwm_i),
  .inhibit_i(inhibit_i),
  .hi_off_i (hi_off_i),
  .lo_off_i (lo_off_i),
  .hi_en_o  (hi_en_o),
  .lo_en_o  (lo_en_o),
  .fault_o  (fault_o)
);

// File: tb/gate_bbm_ctrl_test.sv
module gate_bbm_ctrl_test;
  localparam int unsigned PERIOD = 25;
  localparam int unsigned PCT    = 96;
  localparam int unsigned TO     = 8;
  localparam int unsigned MAX_ON = PERIOD * PCT / 100;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwm = 1'b0, inh = 1'b0, hi_off = 1'b1, lo_off = 1'b1;
  logic hi_en, lo_en, fault;
  int   n_tests = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  gate_bbm_ctrl #(.PERIOD_CYC(PERIOD), .MAX_DUTY_PCT(PCT), .TIMEOUT_CYC(TO)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm), .inhibit_i(inh),
    .hi_off_i(hi_off), .lo_off_i(lo_off),
    .hi_en_o(hi_en), .lo_en_o(lo_en), .fault_o(fault)
  );

  function automatic int pack3(logic h, logic l, logic f);
    return {29'd0, h, l, f};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #25;
    rst_ni = 1'b1;
    #1;
  endtask

  initial begin
    int hi_cnt;
    int hi_dly, lo_dly, run_hi;
    logic pwm_d, inh_d, hi_off_d, lo_off_d, hi_p, lo_p;
    void'($urandom(32'd4242));
    #35;
    rst_ni = 1'b1;
    #1;
    // R8 reset state
    chk("R8 reset outputs", pack3(hi_en, lo_en, fault), 0);
    tick();
    chk("R8 first edge both off", pack3(hi_en, lo_en, fault), 0);
    tick();
    chk("R8 lower on at second edge", pack3(hi_en, lo_en, fault), 3'b010);
    lo_off = 1'b0;
    hi_off = 1'b0;
    tick();
    chk("R4 lower held despite indicators", pack3(hi_en, lo_en, fault), 3'b010);
    hi_off = 1'b1;
    tick();
    chk("R4 lower held", pack3(hi_en, lo_en, fault), 3'b010);
    // rising PWM
    pwm = 1'b1;
    tick();
    chk("R9 lower dropped on pwm rise", pack3(hi_en, lo_en, fault), 0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R2 upper waits for lower off", pack3(hi_en, lo_en, fault), 0);
    end
    lo_off = 1'b1;
    tick();
    chk("R2 upper on after lower off", pack3(hi_en, lo_en, fault), 3'b100);
    hi_off = 1'b0;
    // falling PWM
    pwm = 1'b0;
    tick();
    chk("R9 upper dropped on pwm fall", pack3(hi_en, lo_en, fault), 0);
    for (int i = 0; i < 2; i++) begin
      tick();
      chk("R3 lower waits for upper off", pack3(hi_en, lo_en, fault), 0);
    end
    hi_off = 1'b1;
    tick();
    chk("R3 lower on after upper off", pack3(hi_en, lo_en, fault), 3'b010);
    // R5 on-time clamp
    pwm = 1'b1;
    hi_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (hi_en) hi_cnt++;
    end
    chk("R5 clamped high run length", hi_cnt, MAX_ON - 1);
    chk("R5 lower on after clamp", pack3(hi_en, lo_en, fault), 3'b010);
    pwm = 1'b0;
    tick();
    tick();
    pwm = 1'b1;
    tick();
    tick();
    chk("R5 clamp released after pwm low", pack3(hi_en, lo_en, fault), 3'b100);
    // R6 inhibit
    inh = 1'b1;
    tick();
    chk("R6 inhibit drops gates", pack3(hi_en, lo_en, fault), 0);
    for (int i = 0; i < 6; i++) begin
      pwm = i[0];
      tick();
      chk("R6 gates held off", pack3(hi_en, lo_en, fault), 0);
    end
    inh = 1'b0;
    pwm = 1'b1;
    tick();
    tick();
    chk("R6 resume after inhibit", pack3(hi_en, lo_en, fault), 3'b100);
    // R7 timeout
    hi_off = 1'b0;
    pwm = 1'b0;
    for (int i = 0; i < int'(TO); i++) tick();
    chk("R7 no fault before timeout", pack3(hi_en, lo_en, fault), 0);
    tick();
    chk("R7 fault at timeout", pack3(hi_en, lo_en, fault), 3'b001);
    hi_off = 1'b1;
    lo_off = 1'b1;
    for (int i = 0; i < 5; i++) begin
      pwm = i[0];
      tick();
      chk("R7 fault sticky gates off", pack3(hi_en, lo_en, fault), 3'b001);
    end
    do_reset();
    chk("R7 fault cleared by reset", pack3(hi_en, lo_en, fault), 0);
    // random phase with gate plant
    hi_dly = 0;
    lo_dly = 0;
    run_hi = 0;
    hi_p = 1'b0;
    lo_p = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 6 == 0) pwm = ~pwm;
      inh = ($urandom % 60 == 0);
      pwm_d = pwm;
      inh_d = inh;
      hi_off_d = hi_off;
      lo_off_d = lo_off;
      tick();
      chk("R1 never both on", int'(hi_en && lo_en), 0);
      chk("R7 no fault with prompt plant", int'(fault), 0);
      if (inh_d) chk("R6 inhibit random", pack3(hi_en, lo_en, 1'b0), 0);
      if (hi_en && !hi_p) chk("R2 rise needs lower off", int'(lo_off_d), 1);
      if (lo_en && !lo_p) chk("R3 rise needs upper off", int'(hi_off_d), 1);
      if (!pwm_d) chk("R9 upper low after pwm low", int'(hi_en), 0);
      run_hi = hi_en ? run_hi + 1 : 0;
      if (run_hi >= int'(MAX_ON)) chk("R5 random run bound", run_hi, MAX_ON - 1);
      hi_p = hi_en;
      lo_p = lo_en;
      if (hi_en) begin
        hi_off = 1'b0;
        hi_dly = $urandom % 4;
      end else if (!hi_off) begin
        if (hi_dly == 0) hi_off = 1'b1;
        else hi_dly--;
      end
      if (lo_en) begin
        lo_off = 1'b0;
        lo_dly = $urandom % 4;
      end else if (!lo_off) begin
        if (lo_dly == 0) lo_off = 1'b1;
        else lo_dly--;
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule